// File: doc/BRIEF.md
# SPI-Mode Memory Card Block Data Phase Engine

This block runs the data phase that follows an accepted read or write command on a memory card wired in SPI mode. A single pulse on `start` latches a byte count and a direction. In read direction the engine clocks idle bytes out to the card until the card answers with a start token, then passes each payload byte out on a valid/ready stream. It then clocks in and drops the checksum bytes and one filler byte. In write direction it sends a lead-in idle byte and the start token, takes payload bytes from a valid/ready stream, appends zero-valued checksum and filler bytes, and polls the card until the card stops signalling busy.

The block finishes with a one-cycle `done` pulse and an error code that stays valid until the next accepted start. Error codes: 0 = none, 1 = timeout, 2 = token error, 3 = length error. The byte shifter runs in SPI mode 0 and has two clock rates. The payload bytes use the fast rate. Token search, trailer bytes and busy polling use the slow rate. One control state machine drives the shifter. Its states are IDLE, RD_POLL, RD_DATA, RD_TRAIL, WR_LEAD, WR_TOKEN, WR_DATA, WR_TRAIL, WR_BUSY and DONE. Its transitions are:

- IDLE→RD_POLL or IDLE→WR_LEAD on an accepted start.
- IDLE→DONE on a rejected length.
- RD_POLL→RD_DATA on a start token.
- RD_POLL→DONE on a wrong token or on poll exhaustion.
- RD_DATA→RD_TRAIL after the last payload byte.
- RD_TRAIL→DONE after three bytes.
- WR_LEAD→WR_TOKEN→WR_DATA, one byte each.
- WR_DATA→WR_TRAIL after the last payload byte.
- WR_TRAIL→WR_BUSY after three bytes.
- WR_BUSY→DONE when 0xFF is seen or when polling is exhausted.
- DONE→IDLE always.

Top module: `sdspi_block_xfer`

## Requirements
- R1: A start with a length of 0 or above MAX_LEN (512) goes to DONE. `done` is high in the cycle after the start was sampled, `err` = 3, and no SCK edge occurs.
- R2: In read direction, bytes received as 0xFF count as idle polls. After POLL_LIMIT consecutive idle polls the transfer ends with `err` = 1 and no data is output.
- R3: In read direction, a first non-0xFF byte other than 0xFE ends the transfer with `err` = 2, and `rd_valid` never rises.
- R4: After a 0xFE token, exactly `len` payload bytes appear on `rd_data`/`rd_valid` in arrival order, and MOSI carries 0xFF for every byte of a read.
- R5: After the read payload, three further bytes are clocked and discarded, then `done` pulses with `err` = 0.
- R6: While `rd_valid` is high and `rd_ready` is low, `rd_data` holds steady and no further byte is clocked.
- R7: In write direction, MOSI carries 0xFF, then 0xFE, then the `len` stream bytes in the order accepted.
- R8: After the write payload, three 0x00 bytes are sent.
- R9: After the write trailer, bytes are polled until 0xFF arrives, which ends with `err` = 0. POLL_LIMIT polls without 0xFF end with `err` = 1.
- R10: Every payload byte keeps SCK high for FAST_HALF clock cycles per bit. Every other byte keeps SCK high for SLOW_HALF cycles per bit.
- R11: SPI mode 0: SCK rests low when the block is idle, data is most significant bit first, and MISO is sampled on the SCK rising edge.
- R12: A `start` pulse while a transfer is in progress is ignored. The running transfer neither ends early nor changes direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transfer (sampled in IDLE only) |
| is_write | input | 1 | 1 = write direction, 0 = read direction |
| len | input | LEN_W (10) | Block length in bytes |
| wr_data | input | 8 | Write payload byte |
| wr_valid | input | 1 | Write payload byte available |
| wr_ready | output | 1 | Engine accepts the write byte this cycle |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | Read payload byte available |
| rd_ready | input | 1 | Consumer accepts the read byte |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | SPI data to card |
| miso | input | 1 | SPI data from card |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | Result code: 0 none, 1 timeout, 2 token, 3 length |

## Verification
The hardest situation to reach is back-pressure in the middle of a read payload. The consumer must hold `rd_ready` low after a byte has landed, and the shifter must stay parked while the card model still has more bytes queued. The bench keeps `rd_ready` low from the start of a two-byte read and waits for the first `rd_valid`. For a hundred cycles it then checks that the data holds and that the card model counts no new byte, and only then releases the consumer. The two timeout paths are reached with a card model that never leaves 0xFF (read) or never leaves 0x00 (write busy), and a shortened poll limit.

// File: rtl/sdx_pkg.sv
`timescale 1ns/1ps
package sdx_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_POLL, ST_RD_DATA, ST_RD_TRAIL,
        ST_WR_LEAD, ST_WR_TOKEN, ST_WR_DATA, ST_WR_TRAIL,
        ST_WR_BUSY, ST_DONE
    } xfer_state_t;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_TIMEOUT = 2'd1,
        ERR_TOKEN   = 2'd2,
        ERR_LENGTH  = 2'd3
    } xfer_err_t;

    localparam logic [7:0] BYTE_IDLE  = 8'hFF;
    localparam logic [7:0] BYTE_START = 8'hFE;
    localparam logic [7:0] BYTE_FILL  = 8'h00;
    localparam int         TRAIL_CNT  = 3;
endpackage

// File: rtl/sdx_spi_engine.sv
`timescale 1ns/1ps
module sdx_spi_engine #(
    parameter int FAST_HALF = 2,
    parameter int SLOW_HALF = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       slow,
    input  logic [7:0] tx_byte,
    output logic       fin,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    localparam int MAXH = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
    localparam int HW   = $clog2(MAXH + 1);

    logic          active;
    logic [HW-1:0] half_lim;
    logic [HW-1:0] half_cnt;
    logic [2:0]    bit_cnt;
    logic          sck_q;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;
    logic          fin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active   <= 1'b0;
            half_lim <= '0;
            half_cnt <= '0;
            bit_cnt  <= '0;
            sck_q    <= 1'b0;
            tx_sh    <= 8'hFF;
            rx_sh    <= 8'h00;
            fin_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (!active) begin
                if (go) begin
                    active   <= 1'b1;
                    tx_sh    <= tx_byte;
                    bit_cnt  <= '0;
                    half_cnt <= '0;
                    half_lim <= slow ? HW'(SLOW_HALF - 1) : HW'(FAST_HALF - 1);
                end
            end else if (half_cnt != half_lim) begin
                half_cnt <= half_cnt + 1'b1;
            end else begin
                half_cnt <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_sh <= {rx_sh[6:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        active <= 1'b0;
                        fin_q  <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign fin     = fin_q;
    assign rx_byte = rx_sh;
    assign sck     = sck_q;
    assign mosi    = active ? tx_sh[7] : 1'b1;

    AST_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !active);                                   // R11
    AST_SCK_REST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !sck_q);                               // R11
endmodule

// File: rtl/sdx_xfer_fsm.sv
`timescale 1ns/1ps
module sdx_xfer_fsm
    import sdx_pkg::*;
#(
    parameter int MAX_LEN    = 512,
    parameter int POLL_LIMIT = 1000,
    parameter int LEN_W      = $clog2(MAX_LEN + 1),
    parameter int PW         = $clog2(POLL_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_write,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    input  logic             eng_fin,
    input  logic [7:0]       eng_rx,
    output logic             eng_go,
    output logic             eng_slow,
    output logic [7:0]       eng_tx,
    output logic             done,
    output logic             busy,
    output xfer_err_t        err
);
    xfer_state_t      state;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt;
    logic [PW-1:0]    poll;
    logic             inflight;
    logic [7:0]       rd_data_q;
    logic             rd_valid_q;
    xfer_err_t        err_q;

    wire last_payload = (cnt == len_q - LEN_W'(1));
    wire last_trail   = (cnt == LEN_W'(TRAIL_CNT - 1));
    wire last_poll    = (poll == PW'(POLL_LIMIT - 1));

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            len_q      <= '0;
            cnt        <= '0;
            poll       <= '0;
            inflight   <= 1'b0;
            rd_data_q  <= 8'h00;
            rd_valid_q <= 1'b0;
            err_q      <= ERR_NONE;
        end else begin
            if (rd_valid_q && rd_ready) rd_valid_q <= 1'b0;
            if (eng_go) inflight <= 1'b1;
            unique case (state)
                ST_IDLE: if (start) begin
                    len_q <= len;
                    cnt   <= '0;
                    poll  <= '0;
                    if (len == '0 || len > LEN_W'(MAX_LEN)) begin
                        err_q <= ERR_LENGTH;
                        state <= ST_DONE;
                    end else begin
                        err_q <= ERR_NONE;
                        state <= is_write ? ST_WR_LEAD : ST_RD_POLL;
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: if (eng_fin) begin
                    inflight <= 1'b0;
                    unique case (state)
                        ST_RD_POLL:
                            if (eng_rx == BYTE_IDLE) begin
                                if (last_poll) begin
                                    err_q <= ERR_TIMEOUT;
                                    state <= ST_DONE;
                                end else poll <= poll + 1'b1;
                            end else if (eng_rx == BYTE_START) begin
                                cnt   <= '0;
                                state <= ST_RD_DATA;
                            end else begin
                                err_q <= ERR_TOKEN;
                                state <= ST_DONE;
                            end
                        ST_RD_DATA: begin
                            rd_data_q  <= eng_rx;
                            rd_valid_q <= 1'b1;
                            if (last_payload) begin
                                cnt   <= '0;
                                state <= ST_RD_TRAIL;
                            end else cnt <= cnt + 1'b1;
                        end
                        ST_RD_TRAIL:
                            if (last_trail) state <= ST_DONE;
                            else cnt <= cnt + 1'b1;
                        ST_WR_LEAD:  state <= ST_WR_TOKEN;
                        ST_WR_TOKEN: begin
                            cnt   <= '0;
                            state <= ST_WR_DATA;
                        end
                        ST_WR_DATA:
                            if (last_payload) begin
                                cnt   <= '0;
                                state <= ST_WR_TRAIL;
                            end else cnt <= cnt + 1'b1;
                        ST_WR_TRAIL:
                            if (last_trail) begin
                                poll  <= '0;
                                state <= ST_WR_BUSY;
                            end else cnt <= cnt + 1'b1;
                        ST_WR_BUSY:
                            if (eng_rx == BYTE_IDLE) state <= ST_DONE;
                            else if (last_poll) begin
                                err_q <= ERR_TIMEOUT;
                                state <= ST_DONE;
                            end else poll <= poll + 1'b1;
                        default: state <= ST_IDLE;
                    endcase
                end
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        eng_go   = 1'b0;
        eng_slow = 1'b1;
        eng_tx   = BYTE_IDLE;
        wr_ready = 1'b0;
        done     = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            ST_RD_POLL, ST_RD_TRAIL, ST_WR_BUSY, ST_WR_LEAD: eng_go = !inflight;
            ST_WR_TOKEN: begin
                eng_go = !inflight;
                eng_tx = BYTE_START;
            end
            ST_WR_TRAIL: begin
                eng_go = !inflight;
                eng_tx = BYTE_FILL;
            end
            ST_RD_DATA: begin
                eng_slow = 1'b0;
                eng_go   = !inflight && !rd_valid_q;
            end
            ST_WR_DATA: begin
                eng_slow = 1'b0;
                wr_ready = !inflight;
                eng_go   = !inflight && wr_valid;
                eng_tx   = wr_data;
            end
            default: busy = 1'b0;
        endcase
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;
    assign err      = err_q;

    AST_LEN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && len == '0) |=> (done && err_q == ERR_LENGTH)); // R1
    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        poll < PW'(POLL_LIMIT));                                                      // R2
    AST_NO_DATA_ON_BAD_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_POLL && eng_fin && eng_rx != BYTE_IDLE && eng_rx != BYTE_START)
        |=> !rd_valid_q);                                                             // R3
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_q && !rd_ready) |=> (rd_valid_q && $stable(rd_data_q)));           // R6
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && len == '0) |=> (err_q != ERR_LENGTH));                      // R12
endmodule

// File: rtl/sdspi_block_xfer.sv
`timescale 1ns/1ps
module sdspi_block_xfer
    import sdx_pkg::*;
#(
    parameter int MAX_LEN    = 512,
    parameter int POLL_LIMIT = 1000,
    parameter int FAST_HALF  = 2,
    parameter int SLOW_HALF  = 8,
    parameter int LEN_W      = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_write,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             sck,
    output logic             mosi,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic [1:0]       err
);
    logic       eng_go, eng_slow, eng_fin;
    logic [7:0] eng_tx, eng_rx;
    xfer_err_t  err_w;

    sdx_xfer_fsm #(
        .MAX_LEN(MAX_LEN), .POLL_LIMIT(POLL_LIMIT), .LEN_W(LEN_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write), .len(len),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .eng_fin(eng_fin), .eng_rx(eng_rx), .eng_go(eng_go), .eng_slow(eng_slow),
        .eng_tx(eng_tx), .done(done), .busy(busy), .err(err_w)
    );

    sdx_spi_engine #(
        .FAST_HALF(FAST_HALF), .SLOW_HALF(SLOW_HALF)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .go(eng_go), .slow(eng_slow), .tx_byte(eng_tx),
        .fin(eng_fin), .rx_byte(eng_rx), .sck(sck), .mosi(mosi), .miso(miso)
    );

    assign err = err_w;

    AST_SCK_LOW_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);                                    // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                    // R5
endmodule

// File: tb/sdspi_block_xfer_tb.sv
`timescale 1ns/1ps
module sdspi_block_xfer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_LEN    = 512;
    localparam int POLL       = 50;
    localparam int FAST_H     = 2;
    localparam int SLOW_H     = 4;
    localparam int LEN_W      = $clog2(MAX_LEN + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic is_write = 1'b0;
    logic [LEN_W-1:0] len = '0;
    logic [7:0] wr_data;
    logic wr_valid;
    logic wr_ready;
    logic [7:0] rd_data;
    logic rd_valid;
    logic rd_ready = 1'b1;
    logic sck, mosi;
    logic miso = 1'b1;
    logic busy, done;
    logic [1:0] err;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdspi_block_xfer #(.MAX_LEN(MAX_LEN), .POLL_LIMIT(POLL), .FAST_HALF(FAST_H),
                       .SLOW_HALF(SLOW_H)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write), .len(len),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .sck(sck), .mosi(mosi), .miso(miso), .busy(busy), .done(done), .err(err));

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    // card model: MSB first, drives on falling, samples on rising
    logic [7:0] resp [0:1023];
    logic [7:0] mo   [0:1023];
    int         hw   [0:1023];
    int nb = 0, bitc = 0;
    logic [7:0] cur = 8'hFF, rxs = 8'h00;
    time t_rise = 0;

    always @(posedge sck) begin
        rxs = {rxs[6:0], mosi};
        t_rise = $time;
        bitc++;
        if (bitc == 8) begin
            mo[nb] = rxs;
            bitc = 0;
            nb++;
        end
    end
    always @(negedge sck) begin
        if (bitc == 0) begin
            hw[nb-1] = int'(($time - t_rise) / CLK_PERIOD);
            cur  = resp[nb];
            miso = cur[7];
        end else miso = cur[7-bitc];
    end

    // stream sides
    logic [7:0] wbuf [0:7];
    int wi = 0, wlen = 0;
    assign wr_data  = wbuf[wi[2:0]];
    assign wr_valid = (wi < wlen);
    always @(posedge clk) if (wr_valid && wr_ready) wi <= wi + 1;

    logic [7:0] got [0:15];
    int ng = 0, rdv_seen = 0;
    always @(posedge clk) begin
        if (rd_valid && rd_ready) begin
            got[ng[3:0]] <= rd_data;
            ng <= ng + 1;
        end
        if (rd_valid) rdv_seen <= rdv_seen + 1;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic card_arm(input logic [7:0] fill);
        for (int i = 0; i < 1024; i++) resp[i] = fill;
    endtask

    task automatic card_go();
        @(negedge clk);
        nb = 0; bitc = 0; ng = 0; rdv_seen = 0; wi = 0;
        cur = resp[0]; miso = cur[7];
    endtask

    task automatic kick(input logic w, input int l);
        @(negedge clk);
        start = 1'b1; is_write = w; len = LEN_W'(l);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int e);
        e = -1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done) begin
                e = int'(err);
                return;
            end
        end
    endtask

    task automatic t_reset();
        chk("R11", "sck at reset", int'(sck), 0);
        chk("R1", "done at reset", int'(done), 0);
        chk("R1", "busy at reset", int'(busy), 0);
        chk("R6", "rd_valid at reset", int'(rd_valid), 0);
    endtask

    task automatic t_len_reject(input int l);
        card_arm(8'hFF); card_go();
        @(negedge clk);
        start = 1'b1; is_write = 1'b0; len = LEN_W'(l);
        @(negedge clk);
        start = 1'b0;
        chk("R1", "done after bad length", int'(done), 1);
        chk("R1", "err after bad length", int'(err), 3);
        repeat (20) @(negedge clk);
        chk("R1", "no bytes clocked", nb, 0);
    endtask

    task automatic t_read_ok();
        int e;
        logic [7:0] exp_d [0:3];
        exp_d[0] = 8'h5A; exp_d[1] = 8'hC3; exp_d[2] = 8'h00; exp_d[3] = 8'h81;
        card_arm(8'hFF);
        resp[3] = 8'hFE;
        for (int i = 0; i < 4; i++) resp[4+i] = exp_d[i];
        card_go();
        rd_ready = 1'b1;
        kick(1'b0, 4);
        while (nb < 2) @(negedge clk);
        start = 1'b1; is_write = 1'b1; len = '0;   // R12 stray start
        @(negedge clk);
        start = 1'b0;
        chk("R12", "no early done on stray start", int'(done), 0);
        chk("R12", "still busy after stray start", int'(busy), 1);
        wait_done(e);
        chk("R5", "read err", e, 0);
        chk("R5", "bytes clocked incl trailer", nb, 11);
        chk("R4", "bytes delivered", ng, 4);
        for (int i = 0; i < 4; i++) chk("R4", "read payload byte", int'(got[i]), int'(exp_d[i]));
        for (int i = 0; i < 11; i++) chk("R4", "mosi idle during read", int'(mo[i]), 8'hFF);
        chk("R10", "poll byte slow", hw[0], SLOW_H);
        chk("R10", "payload byte fast", hw[5], FAST_H);
        chk("R10", "trailer byte slow", hw[9], SLOW_H);
    endtask

    task automatic t_read_stall();
        int e, snap;
        logic [7:0] d0;
        card_arm(8'hFF);
        resp[0] = 8'hFE; resp[1] = 8'h11; resp[2] = 8'h22;
        card_go();
        rd_ready = 1'b0;
        kick(1'b0, 2);
        for (int i = 0; i < 5000 && !rd_valid; i++) @(negedge clk);
        d0 = rd_data; snap = nb;
        repeat (100) @(negedge clk);
        chk("R6", "rd_valid held", int'(rd_valid), 1);
        chk("R6", "rd_data held", int'(rd_data), int'(d0));
        chk("R6", "no byte clocked while stalled", nb, snap);
        chk("R6", "first byte value", int'(d0), 8'h11);
        rd_ready = 1'b1;
        wait_done(e);
        chk("R6", "err after stall", e, 0);
        chk("R6", "second byte after release", int'(got[1]), 8'h22);
    endtask

    task automatic t_read_token_err();
        int e;
        card_arm(8'hFF);
        resp[1] = 8'h3C;
        card_go();
        kick(1'b0, 8);
        wait_done(e);
        chk("R3", "token err code", e, 2);
        chk("R3", "bytes clocked", nb, 2);
        chk("R3", "no rd_valid", rdv_seen, 0);
    endtask

    task automatic t_read_timeout();
        int e;
        card_arm(8'hFF); card_go();
        kick(1'b0, 8);
        wait_done(e);
        chk("R2", "read timeout code", e, 1);
        chk("R2", "poll count", nb, POLL);
        chk("R2", "no data", rdv_seen, 0);
    endtask

    task automatic t_write_ok();
        int e;
        wbuf[0] = 8'hA5; wbuf[1] = 8'h01; wbuf[2] = 8'h80;
        card_arm(8'hFF);
        resp[8] = 8'h00; resp[9] = 8'h00;
        card_go();
        wlen = 3;
        kick(1'b1, 3);
        wait_done(e);
        chk("R9", "write err", e, 0);
        chk("R9", "bytes clocked", nb, 11);
        chk("R7", "lead byte", int'(mo[0]), 8'hFF);
        chk("R7", "start token", int'(mo[1]), 8'hFE);
        for (int i = 0; i < 3; i++) chk("R7", "payload", int'(mo[2+i]), int'(wbuf[i]));
        for (int i = 0; i < 3; i++) chk("R8", "trailer zero", int'(mo[5+i]), 0);
        chk("R10", "write token slow", hw[1], SLOW_H);
        chk("R10", "write payload fast", hw[3], FAST_H);
        chk("R10", "busy poll slow", hw[8], SLOW_H);
        wlen = 0;
    endtask

    task automatic t_write_timeout();
        int e;
        wbuf[0] = 8'h77;
        card_arm(8'h00); card_go();
        wlen = 1;
        kick(1'b1, 1);
        wait_done(e);
        chk("R9", "write timeout code", e, 1);
        chk("R9", "bytes clocked", nb, 6 + POLL);
        wlen = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        card_arm(8'hFF);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_len_reject(0);
        t_len_reject(600);
        t_read_ok();
        t_read_stall();
        t_read_token_err();
        t_read_timeout();
        t_write_ok();
        t_write_timeout();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule